// File: doc/BRIEF.md
# I2C Block Transfer Sequencer

This block turns one request (a device word, a register offset, a length and a direction) into the ordered list of byte operations that a byte-level I2C engine carries out. It sends the device address after a START condition. It then sends up to two offset bytes, and for a read it issues a repeated START with the read address. It then moves the data bytes. Write bytes arrive on a valid/ready input stream. Read bytes leave on a valid/ready output stream. A reserved device code selects a legacy addressing scheme in which the offset itself is shifted into the address byte. The requester must split transfers at any page boundary of the target device.

The engine port accepts one operation at a time on a valid/ready handshake, and the engine answers every operation with exactly one response pulse. The operation codes are WRITE (0), READ (1) and STOP (2). A WRITE may ask for a leading START. A READ marked last makes the engine answer that byte with NACK and then place STOP itself. Both data streams follow the usual rules. A transfer occurs on a cycle where valid and ready are both high. The read stream keeps valid and data steady until it is accepted, and it issues no further engine operation meanwhile. A stalled write stream simply holds the sequencer on that byte.

Top module: `i2c_blk_seq`

## Requirements
- R1: Bits 7:1 of the device word give the 7-bit bus address. Bit 0 is ignored and replaced by the direction bit (0 write, 1 read). Bits 15:8 give the number of offset bytes.
- R2: A request with an offset count above 2 completes on the following cycle with done and err high, and no engine operation is issued.
- R3: The offset bytes follow the write address in order of increasing significance: byte i is offset bits 8i+7 down to 8i. Exactly the counted number of bytes is sent.
- R4: After each acknowledged offset byte, no engine operation is issued for at least GAP_CYCLES clock cycles.
- R5: A read with a nonzero offset count sends START with the write address, then the offset bytes, then START with the read address. A read with no offset bytes starts directly with START and the read address.
- R6: A read of N bytes issues N READ operations. Only the final one is marked last, and no STOP follows it. The returned bytes appear on the read stream in order.
- R7: When bits 7:0 of the device word equal LEGACY_DEV, the single address byte after START is {offset[6:0], direction}, and no offset bytes follow, whatever the count.
- R8: A write sends START with the write address, then the offset bytes, then each stream byte as a WRITE. A STOP follows, and the request completes without error.
- R9: A NACK on an address byte, an offset byte or a write data byte causes a STOP operation next. The request then completes with err high, and no further byte is sent.
- R10: While the read stream is stalled, its valid and data hold steady and no engine operation is issued.
- R11: done is high for exactly one cycle per request. A request is accepted only while idle.
- R12: A request of length zero addresses the device, sends the offset bytes, issues STOP and completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer idle, request taken |
| cmd_rd | input | 1 | 1 read, 0 write |
| cmd_dev | input | 16 | Offset count (15:8), bus address (7:1) |
| cmd_off | input | 8*MAX_OFF | Register offset |
| cmd_len | input | LEN_W | Number of data bytes |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion status, valid with done |
| wdat_valid | input | 1 | Write byte present |
| wdat_ready | output | 1 | Write byte taken |
| wdat_data | input | 8 | Write byte |
| rdat_valid | output | 1 | Read byte present |
| rdat_ready | input | 1 | Read byte taken |
| rdat_data | output | 8 | Read byte |
| bcmd_valid | output | 1 | Engine operation present |
| bcmd_ready | input | 1 | Engine takes operation |
| bcmd_op | output | 2 | 0 WRITE, 1 READ, 2 STOP |
| bcmd_start | output | 1 | Precede WRITE with START |
| bcmd_last | output | 1 | READ is final: NACK then STOP |
| bcmd_data | output | 8 | Byte for WRITE |
| brsp_valid | input | 1 | Engine response pulse |
| brsp_nack | input | 1 | Byte was not acknowledged |
| brsp_data | input | 8 | Byte returned by READ |

## Verification
The hardest situations to reach are the aborts that fall in the middle of a request. These are a NACK on the second write data byte while a third still waits on the stream, and a NACK on an offset byte in the middle of the gap schedule. The bench's engine model keeps a running operation index and refuses exactly one chosen index, so each abort point is chosen directly. Read back-pressure is driven by a consumer that withholds ready for several cycles on every byte. The engine's ready also drops every third cycle, so held operations are exercised as well.

// File: rtl/i2cbs_pkg.sv
package i2cbs_pkg;
  typedef enum logic [1:0] {
    BK_WRITE = 2'd0,
    BK_READ  = 2'd1,
    BK_STOP  = 2'd2
  } bop_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_RSP, S_GAP, S_PUSH, S_FIN
  } st_e;

  typedef enum logic [2:0] {
    P_ADDR, P_OFF, P_RADDR, P_DATA, P_STOP
  } ph_e;
endpackage

// File: rtl/i2cbs_byte_mux.sv
module i2cbs_byte_mux
  import i2cbs_pkg::*;
#(
  parameter int MAX_OFF = 2,
  localparam int OFF_W = 8 * MAX_OFF,
  localparam int OCW   = $clog2(MAX_OFF + 1)
) (
  input  ph_e              ph,
  input  logic             legacy,
  input  logic             rw_bit,
  input  logic [6:0]       dev7,
  input  logic [OFF_W-1:0] off,
  input  logic [OCW-1:0]   idx,
  output logic [7:0]       byte_o
);
  logic [7:0] slice [MAX_OFF];
  logic [7:0] off_b;

  for (genvar g = 0; g < MAX_OFF; g++) begin : g_slice
    assign slice[g] = off[8*g +: 8];
  end

  always_comb begin
    off_b = 8'h00;
    for (int k = 0; k < MAX_OFF; k++)
      if (idx == OCW'(k)) off_b = slice[k];
  end

  always_comb begin
    case (ph)
      P_ADDR:  byte_o = legacy ? {off[6:0], rw_bit} : {dev7, rw_bit};
      P_OFF:   byte_o = off_b;
      P_RADDR: byte_o = {dev7, 1'b1};
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2cbs_gap_timer.sv
module i2cbs_gap_timer #(
  parameter int CYC = 6000,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic expire
);
  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      cnt  <= CW'(CYC - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign expire = busy && (cnt == '0);

  p_gap_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  p_gap_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !go && cnt != '0) |=> (busy && cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/i2c_blk_seq.sv
module i2c_blk_seq
  import i2cbs_pkg::*;
#(
  parameter int         MAX_OFF    = 2,
  parameter int         LEN_W      = 8,
  parameter int         GAP_CYCLES = 6000,
  parameter logic [7:0] LEGACY_DEV = 8'h00,
  localparam int OFF_W = 8 * MAX_OFF,
  localparam int OCW   = $clog2(MAX_OFF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_rd,
  input  logic [15:0]      cmd_dev,
  input  logic [OFF_W-1:0] cmd_off,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             done,
  output logic             err,
  input  logic             wdat_valid,
  output logic             wdat_ready,
  input  logic [7:0]       wdat_data,
  output logic             rdat_valid,
  input  logic             rdat_ready,
  output logic [7:0]       rdat_data,
  output logic             bcmd_valid,
  input  logic             bcmd_ready,
  output logic [1:0]       bcmd_op,
  output logic             bcmd_start,
  output logic             bcmd_last,
  output logic [7:0]       bcmd_data,
  input  logic             brsp_valid,
  input  logic             brsp_nack,
  input  logic [7:0]       brsp_data
);
  localparam logic [7:0] OFF_LIM = 8'(MAX_OFF);

  st_e              st;
  ph_e              ph;
  logic             rd_q, legacy_q, err_q;
  logic [6:0]       dev_q;
  logic [OFF_W-1:0] off_q;
  logic [OCW-1:0]   ocnt_q, idx_q;
  logic [LEN_W-1:0] rem_q;
  logic [7:0]       rbyte_q;
  logic [7:0]       mux_byte;
  logic             gap_go, gap_done, rsp_hit, rd_data_ph, wr_data_ph;

  assign rsp_hit    = (st == S_RSP) && brsp_valid;
  assign rd_data_ph = (ph == P_DATA) && rd_q;
  assign wr_data_ph = (ph == P_DATA) && !rd_q;
  assign gap_go     = rsp_hit && (ph == P_OFF) && !brsp_nack;

  i2cbs_byte_mux #(.MAX_OFF(MAX_OFF)) u_mux (
    .ph     (ph),
    .legacy (legacy_q),
    .rw_bit (rd_q && (ocnt_q == '0)),
    .dev7   (dev_q),
    .off    (off_q),
    .idx    (idx_q),
    .byte_o (mux_byte)
  );

  i2cbs_gap_timer #(.CYC(GAP_CYCLES)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (gap_go),
    .expire (gap_done)
  );

  // Engine operation and stream handshakes
  always_comb begin
    bcmd_valid = (st == S_CMD) && (!wr_data_ph || wdat_valid);
    if (ph == P_STOP)   bcmd_op = BK_STOP;
    else if (rd_data_ph) bcmd_op = BK_READ;
    else                bcmd_op = BK_WRITE;
    bcmd_start = (ph == P_ADDR) || (ph == P_RADDR);
    bcmd_last  = rd_data_ph && (rem_q == LEN_W'(1));
    bcmd_data  = wr_data_ph ? wdat_data : mux_byte;
  end

  assign wdat_ready = (st == S_CMD) && wr_data_ph && bcmd_ready;
  assign cmd_ready  = (st == S_IDLE);
  assign rdat_valid = (st == S_PUSH);
  assign rdat_data  = rbyte_q;
  assign done       = (st == S_FIN);
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= P_ADDR;
      rd_q     <= 1'b0;
      legacy_q <= 1'b0;
      err_q    <= 1'b0;
      dev_q    <= '0;
      off_q    <= '0;
      ocnt_q   <= '0;
      idx_q    <= '0;
      rem_q    <= '0;
      rbyte_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          rd_q     <= cmd_rd;
          dev_q    <= cmd_dev[7:1];
          off_q    <= cmd_off;
          rem_q    <= cmd_len;
          idx_q    <= '0;
          ph       <= P_ADDR;
          legacy_q <= (cmd_dev[7:0] == LEGACY_DEV);
          ocnt_q   <= (cmd_dev[7:0] == LEGACY_DEV) ? '0 : cmd_dev[8 +: OCW];
          if (cmd_dev[15:8] > OFF_LIM) begin
            err_q <= 1'b1;
            st    <= S_FIN;
          end else begin
            err_q <= 1'b0;
            st    <= S_CMD;
          end
        end
        S_CMD: if (bcmd_valid && bcmd_ready) st <= S_RSP;
        S_RSP: if (brsp_valid) begin
          if (brsp_nack && !rd_data_ph && ph != P_STOP) begin
            err_q <= 1'b1;
            ph    <= P_STOP;
            st    <= S_CMD;
          end else begin
            case (ph)
              P_ADDR: begin
                st <= S_CMD;
                if (ocnt_q != '0) begin
                  ph    <= P_OFF;
                  idx_q <= '0;
                end else begin
                  ph <= (rem_q == '0) ? P_STOP : P_DATA;
                end
              end
              P_OFF:   st <= S_GAP;
              P_RADDR: begin
                st <= S_CMD;
                ph <= (rem_q == '0) ? P_STOP : P_DATA;
              end
              P_DATA: begin
                if (rd_q) begin
                  rbyte_q <= brsp_data;
                  st      <= S_PUSH;
                end else begin
                  rem_q <= rem_q - LEN_W'(1);
                  if (rem_q == LEN_W'(1)) ph <= P_STOP;
                  st <= S_CMD;
                end
              end
              default: st <= S_FIN;
            endcase
          end
        end
        S_GAP: if (gap_done) begin
          st <= S_CMD;
          if (idx_q + OCW'(1) == ocnt_q) begin
            if (rd_q)                ph <= P_RADDR;
            else if (rem_q == '0)    ph <= P_STOP;
            else                     ph <= P_DATA;
          end else begin
            idx_q <= idx_q + OCW'(1);
            ph    <= P_OFF;
          end
        end
        S_PUSH: if (rdat_ready) begin
          rem_q <= rem_q - LEN_W'(1);
          st    <= (rem_q == LEN_W'(1)) ? S_FIN : S_CMD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_dev[15:8] > OFF_LIM) |=> (done && err && !bcmd_valid));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_rdat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdat_valid && !rdat_ready) |=> (rdat_valid && $stable(rdat_data)));
  p_quiet_on_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_valid |-> !bcmd_valid);
  p_bcmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bcmd_valid && !bcmd_ready) |=> (bcmd_valid && $stable(bcmd_op) && $stable(bcmd_start)));
  p_nack_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && brsp_nack && !rd_data_ph && ph != P_STOP) |=> (bcmd_valid && bcmd_op == 2'd2));
endmodule

// File: tb/sim_i2c_blk_seq.sv
module sim_i2c_blk_seq;
  localparam int GAP = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_rd = 1'b0;
  logic [15:0] cmd_dev = '0, cmd_off = '0;
  logic [7:0]  cmd_len = '0;
  logic        cmd_ready, done, err;
  logic        wdat_valid, wdat_ready;
  logic [7:0]  wdat_data;
  logic        rdat_valid, rdat_ready = 1'b0;
  logic [7:0]  rdat_data;
  logic        bcmd_valid, bcmd_ready = 1'b0, bcmd_start, bcmd_last;
  logic [1:0]  bcmd_op;
  logic [7:0]  bcmd_data;
  logic        brsp_valid = 1'b0, brsp_nack = 1'b0;
  logic [7:0]  brsp_data = '0;

  i2c_blk_seq #(.GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rd(cmd_rd),
    .cmd_dev(cmd_dev), .cmd_off(cmd_off), .cmd_len(cmd_len),
    .done(done), .err(err),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_data(wdat_data),
    .rdat_valid(rdat_valid), .rdat_ready(rdat_ready), .rdat_data(rdat_data),
    .bcmd_valid(bcmd_valid), .bcmd_ready(bcmd_ready), .bcmd_op(bcmd_op),
    .bcmd_start(bcmd_start), .bcmd_last(bcmd_last), .bcmd_data(bcmd_data),
    .brsp_valid(brsp_valid), .brsp_nack(brsp_nack), .brsp_data(brsp_data)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Engine model: logs operations, answers each two cycles later
  logic [11:0] lg [0:255];
  int          lc [0:255];
  int          n = 0, pend = 0, nack_at = -1;
  logic        pnack = 1'b0;
  logic [7:0]  pdata = '0;
  always @(posedge clk) begin
    brsp_valid <= 1'b0;
    if (pend == 1) begin
      brsp_valid <= 1'b1;
      brsp_nack  <= pnack;
      brsp_data  <= pdata;
    end
    if (pend != 0) pend <= pend - 1;
    if (bcmd_valid && bcmd_ready) begin
      lg[n] <= {bcmd_op, bcmd_start, bcmd_last, bcmd_data};
      lc[n] <= cyc;
      pnack <= (n == nack_at);
      pdata <= 8'(8'h30 + n);
      n     <= n + 1;
      pend  <= 2;
    end
  end
  always @(negedge clk) bcmd_ready = (cyc % 3) != 0;

  // Write stream source
  logic [7:0] wbuf [0:255];
  int wptr = 0, wtop = 0;
  assign wdat_valid = wptr < wtop;
  assign wdat_data  = wbuf[wptr[7:0]];
  always @(posedge clk) if (wdat_valid && wdat_ready) wptr <= wptr + 1;

  // Read stream sink with back-pressure
  logic [7:0] rbuf [0:255];
  int rcnt = 0, bp_set = 0, bpc = 0, stalls = 0, hold_bad = 0;
  logic prev_stall = 1'b0;
  logic [7:0] prev_d = '0;
  always @(negedge clk) begin
    if (!rdat_valid) bpc = bp_set;
    else if (bpc > 0) bpc = bpc - 1;
    rdat_ready = rdat_valid && (bpc == 0);
  end
  always @(posedge clk) begin
    if (rdat_valid && rdat_ready) begin
      rbuf[rcnt[7:0]] <= rdat_data;
      rcnt <= rcnt + 1;
    end
    if (prev_stall && (!rdat_valid || rdat_data != prev_d)) hold_bad <= hold_bad + 1;
    if (rdat_valid && bcmd_valid) hold_bad <= hold_bad + 1;
    if (rdat_valid && !rdat_ready) stalls <= stalls + 1;
    prev_stall <= rdat_valid && !rdat_ready;
    prev_d     <= rdat_data;
  end

  // Completion monitor
  int ndone = 0, dbl = 0;
  logic last_err = 1'b0, prev_done = 1'b0;
  always @(posedge clk) begin
    if (done) begin
      ndone    <= ndone + 1;
      last_err <= err;
      if (prev_done) dbl <= dbl + 1;
    end
    prev_done <= done;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [11:0] ex [0:31];
  int ex_n = 0;
  function automatic logic [11:0] enc(input int op, input bit s, input bit l, input logic [7:0] d);
    return {2'(op), s, l, d};
  endfunction
  task automatic push(input logic [11:0] v);
    ex[ex_n] = v;
    ex_n++;
  endtask
  task automatic cmp_log(input string req, input int base);
    check(n - base == ex_n, {req, " op count"}, n - base, ex_n);
    for (int i = 0; i < ex_n && i < n - base; i++)
      check(lg[base + i] == ex[i], {req, " op"}, int'(lg[base + i]), int'(ex[i]));
    ex_n = 0;
  endtask

  task automatic issue(input bit rd, input logic [15:0] dev, input logic [15:0] off,
                       input int len, output bit e);
    int d0;
    d0 = ndone;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_dev = dev; cmd_off = off; cmd_len = 8'(len);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (ndone == d0) @(negedge clk);
    @(negedge clk);
    e = last_err;
    check(!cmd_valid && cmd_ready, "R11 idle after done", int'(cmd_ready), 1);
  endtask

  task automatic load_w(input int len, input logic [7:0] b0);
    for (int i = 0; i < len; i++) wbuf[(wptr + i) % 256] = 8'(b0 + 8'(i * 17));
    wtop = wptr + len;
  endtask

  task automatic t_reset;
    check(cmd_ready == 1'b1, "R11 reset ready", int'(cmd_ready), 1);
    check(!done && !bcmd_valid && !rdat_valid && !wdat_ready, "R11 reset quiet",
          int'({done, bcmd_valid, rdat_valid, wdat_ready}), 0);
  endtask

  task automatic t_write_two_off;
    int b; bit e;
    b = n; load_w(3, 8'h11);
    issue(1'b0, 16'h02A0, 16'h1234, 3, e);
    push(enc(0,1,0,8'hA0)); push(enc(0,0,0,8'h34)); push(enc(0,0,0,8'h12));
    push(enc(0,0,0,8'h11)); push(enc(0,0,0,8'h22)); push(enc(0,0,0,8'h33));
    push(enc(2,0,0,8'h00));
    cmp_log("R3 R8 write", b);
    check(e == 1'b0, "R8 write ok", int'(e), 0);
    check(lc[b+2] - lc[b+1] > GAP + 1, "R4 gap after first offset", lc[b+2] - lc[b+1], GAP + 2);
    check(lc[b+3] - lc[b+2] > GAP + 1, "R4 gap after last offset", lc[b+3] - lc[b+2], GAP + 2);
    wtop = wptr;
  endtask

  task automatic t_read_one_off;
    int b, r0; bit e;
    b = n; r0 = rcnt; bp_set = 4;
    issue(1'b1, 16'h0150, 16'h0077, 3, e);
    push(enc(0,1,0,8'h50)); push(enc(0,0,0,8'h77)); push(enc(0,1,0,8'h51));
    push(enc(1,0,0,8'h00)); push(enc(1,0,0,8'h00)); push(enc(1,0,1,8'h00));
    cmp_log("R5 R6 read with offset", b);
    check(e == 1'b0, "R6 read ok", int'(e), 0);
    check(rcnt - r0 == 3, "R6 byte count", rcnt - r0, 3);
    for (int k = 0; k < 3; k++)
      check(rbuf[(r0 + k) % 256] == 8'(8'h30 + b + 3 + k), "R6 read order",
            int'(rbuf[(r0 + k) % 256]), 8'h30 + b + 3 + k);
    check(stalls > 0 && hold_bad == 0, "R10 stall hold", hold_bad, 0);
    bp_set = 0;
  endtask

  task automatic t_read_no_off;
    int b, r0; bit e;
    b = n; r0 = rcnt;
    issue(1'b1, 16'h00C2, 16'h0000, 2, e);
    push(enc(0,1,0,8'hC3)); push(enc(1,0,0,8'h00)); push(enc(1,0,1,8'h00));
    cmp_log("R1 R5 direct read", b);
    check(e == 1'b0 && rcnt - r0 == 2, "R6 short read", rcnt - r0, 2);
  endtask

  task automatic t_reject;
    int b; bit e;
    b = n;
    issue(1'b0, 16'h0350, 16'h0001, 1, e);
    check(e == 1'b1, "R2 reject err", int'(e), 1);
    check(n == b, "R2 no bus ops", n - b, 0);
  endtask

  task automatic t_legacy;
    int b; bit e;
    b = n;
    issue(1'b1, 16'h0100, 16'h0055, 2, e);
    push(enc(0,1,0,8'hAB)); push(enc(1,0,0,8'h00)); push(enc(1,0,1,8'h00));
    cmp_log("R7 legacy read", b);
    check(e == 1'b0, "R7 legacy ok", int'(e), 0);
  endtask

  task automatic t_nack_data;
    int b, w0; bit e;
    b = n; w0 = wptr; load_w(3, 8'hAA);
    nack_at = b + 2;
    issue(1'b0, 16'h0050, 16'h0000, 3, e);
    push(enc(0,1,0,8'h50)); push(enc(0,0,0,8'hAA)); push(enc(0,0,0,8'hBB));
    push(enc(2,0,0,8'h00));
    cmp_log("R9 data nack", b);
    check(e == 1'b1, "R9 data nack err", int'(e), 1);
    check(wptr - w0 == 2, "R9 stream stops", wptr - w0, 2);
    nack_at = -1; wtop = wptr;
  endtask

  task automatic t_nack_addr_read;
    int b; bit e;
    b = n; nack_at = b;
    issue(1'b1, 16'h0150, 16'h0004, 2, e);
    push(enc(0,1,0,8'h50)); push(enc(2,0,0,8'h00));
    cmp_log("R9 address nack", b);
    check(e == 1'b1, "R9 address nack err", int'(e), 1);
    nack_at = -1;
  endtask

  task automatic t_nack_offset;
    int b; bit e;
    b = n; nack_at = b + 1; load_w(1, 8'h5C);
    issue(1'b0, 16'h0250, 16'hBEEF, 1, e);
    push(enc(0,1,0,8'h50)); push(enc(0,0,0,8'hEF)); push(enc(2,0,0,8'h00));
    cmp_log("R9 offset nack", b);
    check(e == 1'b1, "R9 offset nack err", int'(e), 1);
    nack_at = -1; wtop = wptr;
  endtask

  task automatic t_zero_len;
    int b; bit e;
    b = n;
    issue(1'b0, 16'h01A1, 16'h0009, 0, e);
    push(enc(0,1,0,8'hA0)); push(enc(0,0,0,8'h09)); push(enc(2,0,0,8'h00));
    cmp_log("R1 R12 zero length", b);
    check(e == 1'b0, "R12 zero length ok", int'(e), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_write_two_off;
    t_read_one_off;
    t_read_no_off;
    t_reject;
    t_legacy;
    t_nack_data;
    t_nack_addr_read;
    t_nack_offset;
    t_zero_len;
    check(ndone == 9, "R11 one done per request", ndone, 9);
    check(dbl == 0, "R11 done single cycle", dbl, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", ndone, 9);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule